// File: doc/BRIEF.md
# Nibble-Encoded Stack Processor Core

This block runs a byte-wide instruction stream on a small stack machine. Every instruction byte carries a 4-bit function code in its upper half and a 4-bit immediate in its lower half. Immediates wider than four bits, and the extended opcodes of the operate function, are built up in an operand register over a series of prefix bytes. The final non-prefix byte then uses the full accumulated value.

Computation happens on a three-register evaluation stack (A on top, then B, then C), so arithmetic carries no address fields. Local variables sit in a word memory at a fixed workspace base plus the operand, which keeps the per-process context down to that one pointer. Instruction bytes arrive through a valid/ready fetch port addressed by the core. Workspace loads and stores go through a simple word memory port whose read data returns one cycle after the request. Any byte the core does not define stops the core for good and raises a sticky error flag.

Top module: `nib_stack_core`

## Requirements
- R1: After reset, A, B and C read 0, `fetch_addr` is 0, `ibyte_ready` is 1, and `halted` and `err_flag` are 0.
- R2: A byte is split into function code = bits 7:4 and immediate = bits 3:0. The immediate is ORed into the operand register. Function 0x3 (load constant) pushes the resulting operand.
- R3: Function 0x2 (prefix) sets the operand register to (operand OR immediate) shifted left by 4. Chains of prefixes build wide constants. Every non-prefix instruction clears the operand register once it has executed.
- R4: Function 0x6 (negative prefix) sets the operand register to the bitwise complement of (operand OR immediate), shifted left by 4. For example, bytes 0x60 then 0x3F load 0xFFFF.
- R5: A push moves the stack down: C takes B, B takes A, and A takes the new value.
- R6: Function 0x1 (load local) pushes memory word [WS_BASE + operand]. Function 0x5 (store local) writes A to [WS_BASE + operand] and then sets A to B and B to C. C keeps its value. The default WS_BASE is 0x40, and memory addresses wrap at 8 bits.
- R7: Function 0x4 (add constant) sets A to A + operand, modulo 2^16. B and C are unchanged.
- R8: Function 0xF (operate) takes the operand as a sub-code. Sub-code 0 swaps A and B. Sub-code 1 sets A to B + A and B to C. Sub-code 2 sets A to B - A and B to C. C is unchanged in every case.
- R9: Function 0x0 (jump) sets the fetch address to (address of the next byte + operand), modulo 2^12. Function 0x7 (conditional jump) takes the same branch only when A is 0, with the stack unchanged. When A is not 0 it does not jump, and instead sets A to B and B to C.
- R10: Function codes 0x8 to 0xE, and operate sub-codes other than 0, 1 and 2, set `err_flag` and `halted` permanently. The stack is unchanged, no later byte is executed, and `ibyte_ready` stays 0.
- R11: A byte is taken only on a cycle where `ibyte_valid` and `ibyte_ready` are both 1. While `ibyte_valid` is low, `fetch_addr` holds and `ibyte_ready` stays 1. With any stall pattern, a program gives the same results as it does with no stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ibyte_valid | input | 1 | Instruction byte on `ibyte_data` is valid |
| ibyte_data | input | 8 | Instruction byte at `fetch_addr` |
| ibyte_ready | output | 1 | Core accepts a byte this cycle |
| fetch_addr | output | IAW (12) | Address of the byte requested |
| mem_req | output | 1 | Workspace memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | MAW (8) | Workspace word address |
| mem_wdata | output | DW (16) | Write data (A) |
| mem_rdata | input | DW (16) | Read data, valid the cycle after a read request |
| stk_a | output | DW (16) | Stack register A (top) |
| stk_b | output | DW (16) | Stack register B |
| stk_c | output | DW (16) | Stack register C |
| halted | output | 1 | Core has stopped fetching |
| err_flag | output | 1 | Sticky undefined-instruction flag |

## Verification
If the operand register is left dirty, the next load constant or offset comes out wrong. That shows up on `stk_a` or `mem_addr` within two or three cycles of that instruction. A stack that shifts wrongly on a push or pop shows up on `stk_b`/`stk_c` on the very next cycle. A wrong jump target shows on `fetch_addr` one cycle after the jump executes, and from then on the final stack and memory values differ from the reference interpreter. A fault in the error path shows as `ibyte_ready` rising again, or as changed stack values after `halted`.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam logic [3:0] FN_JMP = 4'h0;
  localparam logic [3:0] FN_LDL = 4'h1;
  localparam logic [3:0] FN_PFX = 4'h2;
  localparam logic [3:0] FN_LDC = 4'h3;
  localparam logic [3:0] FN_ADC = 4'h4;
  localparam logic [3:0] FN_STL = 4'h5;
  localparam logic [3:0] FN_NFX = 4'h6;
  localparam logic [3:0] FN_CJ  = 4'h7;
  localparam logic [3:0] FN_OPR = 4'hF;

  localparam int unsigned SUB_REV = 0;
  localparam int unsigned SUB_ADD = 1;
  localparam int unsigned SUB_SUB = 2;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_LOAD, ST_HALT} core_state_t;
  typedef enum logic [2:0] {SK_HOLD, SK_PUSH, SK_POP, SK_SETA, SK_SWAP} stk_op_t;
endpackage

// File: rtl/nib_fetch.sv
module nib_fetch #(
  parameter int IAW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fetch_en,
  input  logic           ibyte_valid,
  input  logic [7:0]     ibyte_data,
  input  logic           jump_en,
  input  logic [IAW-1:0] jump_ofs,
  output logic           ibyte_ready,
  output logic           accept,
  output logic [IAW-1:0] fetch_addr,
  output logic [7:0]     ir
);
  logic [IAW-1:0] iptr_q;

  function automatic logic [IAW-1:0] branch_target(input logic [IAW-1:0] nxt,
                                                   input logic [IAW-1:0] ofs);
    return nxt + ofs;
  endfunction

  assign ibyte_ready = fetch_en;
  assign accept      = ibyte_valid && fetch_en;
  assign fetch_addr  = iptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iptr_q <= '0;
      ir     <= '0;
    end else if (accept) begin
      iptr_q <= iptr_q + 1'b1;
      ir     <= ibyte_data;
    end else if (jump_en) begin
      iptr_q <= branch_target(iptr_q, jump_ofs);
    end
  end
endmodule

// File: rtl/nib_operand.sv
module nib_operand #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [3:0]    nib,
  input  logic          do_pfx,
  input  logic          do_nfx,
  output logic [DW-1:0] op_full,
  output logic [DW-1:0] oper_q
);
  localparam int PADW = DW - 4;

  function automatic logic [DW-1:0] merge_nib(input logic [DW-1:0] acc,
                                              input logic [3:0] n);
    return acc | {{PADW{1'b0}}, n};
  endfunction

  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] v, input logic neg);
    logic [DW-1:0] t;
    t = neg ? ~v : v;
    return t << 4;
  endfunction

  assign op_full = merge_nib(oper_q, nib);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oper_q <= '0;
    end else if (step) begin
      if (do_pfx || do_nfx) oper_q <= shift_in(op_full, do_nfx);
      else                  oper_q <= '0;
    end
  end
endmodule

// File: rtl/nib_stack.sv
module nib_stack
  import nib_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_op_t       op,
  input  logic [DW-1:0] val,
  output logic [DW-1:0] a,
  output logic [DW-1:0] b,
  output logic [DW-1:0] c
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a <= '0;
      b <= '0;
      c <= '0;
    end else begin
      case (op)
        SK_PUSH: begin
          c <= b;
          b <= a;
          a <= val;
        end
        SK_POP: begin
          a <= val;
          b <= c;
        end
        SK_SETA: a <= val;
        SK_SWAP: begin
          a <= b;
          b <= a;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nib_stack_core.sv
module nib_stack_core
  import nib_pkg::*;
#(
  parameter int          DW      = 16,
  parameter int          IAW     = 12,
  parameter int          MAW     = 8,
  parameter int unsigned WS_BASE = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ibyte_valid,
  input  logic [7:0]     ibyte_data,
  output logic           ibyte_ready,
  output logic [IAW-1:0] fetch_addr,
  output logic           mem_req,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [DW-1:0]  stk_a,
  output logic [DW-1:0]  stk_b,
  output logic [DW-1:0]  stk_c,
  output logic           halted,
  output logic           err_flag
);
  localparam logic [MAW-1:0] WS_ADDR = MAW'(WS_BASE);

  core_state_t    state_q, state_d;
  logic           accept, jump_en, dec_err, exec_en;
  logic [7:0]     ir;
  logic [3:0]     fn;
  logic [DW-1:0]  op_full, oper_q;
  stk_op_t        stk_op;
  logic [DW-1:0]  stk_val;
  logic           is_pfx, is_nfx;
  logic           err_q;

  // named internal events for the checker
  logic ev_prefix, ev_oper_clear, ev_push, ev_pop, ev_err;

  function automatic logic [DW-1:0] opr_result(input logic sub,
                                               input logic [DW-1:0] top,
                                               input logic [DW-1:0] nxt);
    return sub ? (nxt - top) : (nxt + top);
  endfunction

  function automatic logic [MAW-1:0] local_addr(input logic [DW-1:0] ofs);
    return WS_ADDR + ofs[MAW-1:0];
  endfunction

  assign fn      = ir[7:4];
  assign exec_en = (state_q == ST_EXEC);
  assign is_pfx  = exec_en && (fn == FN_PFX);
  assign is_nfx  = exec_en && (fn == FN_NFX);

  nib_fetch #(.IAW(IAW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_en   (state_q == ST_FETCH),
    .ibyte_valid(ibyte_valid),
    .ibyte_data (ibyte_data),
    .jump_en    (jump_en),
    .jump_ofs   (op_full[IAW-1:0]),
    .ibyte_ready(ibyte_ready),
    .accept     (accept),
    .fetch_addr (fetch_addr),
    .ir         (ir)
  );

  nib_operand #(.DW(DW)) u_operand (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (exec_en),
    .nib    (ir[3:0]),
    .do_pfx (is_pfx),
    .do_nfx (is_nfx),
    .op_full(op_full),
    .oper_q (oper_q)
  );

  nib_stack #(.DW(DW)) u_stack (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (stk_op),
    .val  (stk_val),
    .a    (stk_a),
    .b    (stk_b),
    .c    (stk_c)
  );

  assign mem_addr  = local_addr(op_full);
  assign mem_wdata = stk_a;

  always_comb begin
    state_d = state_q;
    stk_op  = SK_HOLD;
    stk_val = stk_a;
    jump_en = 1'b0;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    dec_err = 1'b0;
    case (state_q)
      ST_FETCH: if (accept) state_d = ST_EXEC;
      ST_EXEC: begin
        state_d = ST_FETCH;
        case (fn)
          FN_JMP: jump_en = 1'b1;
          FN_LDL: begin
            mem_req = 1'b1;
            state_d = ST_LOAD;
          end
          FN_PFX, FN_NFX: ;
          FN_LDC: begin
            stk_op  = SK_PUSH;
            stk_val = op_full;
          end
          FN_ADC: begin
            stk_op  = SK_SETA;
            stk_val = stk_a + op_full;
          end
          FN_STL: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            stk_op  = SK_POP;
            stk_val = stk_b;
          end
          FN_CJ: begin
            if (stk_a == '0) begin
              jump_en = 1'b1;
            end else begin
              stk_op  = SK_POP;
              stk_val = stk_b;
            end
          end
          FN_OPR: begin
            if (op_full == DW'(SUB_REV)) begin
              stk_op = SK_SWAP;
            end else if (op_full == DW'(SUB_ADD) || op_full == DW'(SUB_SUB)) begin
              stk_op  = SK_POP;
              stk_val = opr_result(op_full == DW'(SUB_SUB), stk_a, stk_b);
            end else begin
              dec_err = 1'b1;
            end
          end
          default: dec_err = 1'b1;
        endcase
        if (dec_err) state_d = ST_HALT;
      end
      ST_LOAD: begin
        stk_op  = SK_PUSH;
        stk_val = mem_rdata;
        state_d = ST_FETCH;
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (dec_err) err_q <= 1'b1;
    end
  end

  assign halted   = (state_q == ST_HALT);
  assign err_flag = err_q;

  assign ev_prefix     = is_pfx || is_nfx;
  assign ev_oper_clear = exec_en && !(is_pfx || is_nfx);
  assign ev_push       = (stk_op == SK_PUSH);
  assign ev_pop        = (stk_op == SK_POP);
  assign ev_err        = dec_err;
endmodule

// File: rtl/nib_stack_core_chk.sv
module nib_stack_core_chk #(
  parameter int DW  = 16,
  parameter int IAW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ibyte_valid,
  input logic           ibyte_ready,
  input logic [IAW-1:0] fetch_addr,
  input logic           halted,
  input logic           err_flag,
  input logic           mem_req,
  input logic           mem_we,
  input logic [DW-1:0]  stk_a,
  input logic [DW-1:0]  stk_b,
  input logic [DW-1:0]  stk_c,
  input logic [DW-1:0]  oper_q,
  input logic           ev_prefix,
  input logic           ev_oper_clear,
  input logic           ev_push,
  input logic           ev_pop,
  input logic           ev_err
);
  p_halt_no_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !ibyte_ready);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> (err_flag && halted));

  p_err_stack_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> (halted && $stable(stk_a) && $stable(stk_b) && $stable(stk_c)));

  p_accept_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ibyte_valid && ibyte_ready) |=> !ibyte_ready);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ibyte_ready && !ibyte_valid) |=> ($stable(fetch_addr) && ibyte_ready));

  p_prefix_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prefix |=> (oper_q[3:0] == 4'h0));

  p_oper_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_oper_clear |=> (oper_q == '0));

  p_push_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> (stk_b == $past(stk_a) && stk_c == $past(stk_b)));

  p_pop_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |=> (stk_b == $past(stk_c) && stk_c == $past(stk_c)));

  p_write_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
endmodule

bind nib_stack_core nib_stack_core_chk #(.DW(DW), .IAW(IAW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ibyte_valid  (ibyte_valid),
  .ibyte_ready  (ibyte_ready),
  .fetch_addr   (fetch_addr),
  .halted       (halted),
  .err_flag     (err_flag),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .stk_a        (stk_a),
  .stk_b        (stk_b),
  .stk_c        (stk_c),
  .oper_q       (oper_q),
  .ev_prefix    (ev_prefix),
  .ev_oper_clear(ev_oper_clear),
  .ev_push      (ev_push),
  .ev_pop       (ev_pop),
  .ev_err       (ev_err)
);

// File: tb/nib_stack_core_bench.sv
`timescale 1ns/1ps
module nib_stack_core_bench;
  localparam int WS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ibyte_valid = 1'b0;
  logic [7:0]  ibyte_data;
  logic        ibyte_ready;
  logic [11:0] fetch_addr;
  logic        mem_req, mem_we;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [15:0] stk_a, stk_b, stk_c;
  logic        halted, err_flag;

  logic [7:0]  prog [64];
  logic [15:0] mem  [256];
  logic [15:0] mmem [256];
  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  nib_stack_core u_nib_stack_core (
    .clk(clk), .rst_n(rst_n),
    .ibyte_valid(ibyte_valid), .ibyte_data(ibyte_data), .ibyte_ready(ibyte_ready),
    .fetch_addr(fetch_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .stk_a(stk_a), .stk_b(stk_b), .stk_c(stk_c),
    .halted(halted), .err_flag(err_flag)
  );

  always_comb ibyte_data = prog[fetch_addr[5:0]];

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [127:0] v, input int len);
    for (int i = 0; i < 64; i++) prog[i] = 8'h80;
    for (int i = 0; i < len; i++) prog[i] = v[8*(len-1-i) +: 8];
  endtask

  // independent interpreter of the requirements
  task automatic model_run(output logic [15:0] ea, output logic [15:0] eb,
                           output logic [15:0] ec, output logic eerr);
    logic [11:0] pc;
    logic [15:0] o, opr, a, b, c;
    logic [7:0]  ins, ad;
    bit stop;
    pc = 0; opr = 0; a = 0; b = 0; c = 0; stop = 0; eerr = 0;
    for (int s = 0; s < 200 && !stop; s++) begin
      ins = prog[pc[5:0]];
      pc  = pc + 12'd1;
      o   = opr | {12'h000, ins[3:0]};
      opr = 16'h0;
      ad  = o[7:0] + 8'(WS);
      case (ins[7:4])
        4'h0: pc = pc + o[11:0];
        4'h1: begin c = b; b = a; a = mmem[ad]; end
        4'h2: opr = o << 4;
        4'h3: begin c = b; b = a; a = o; end
        4'h4: a = a + o;
        4'h5: begin mmem[ad] = a; a = b; b = c; end
        4'h6: opr = (~o) << 4;
        4'h7: if (a == 16'h0) pc = pc + o[11:0]; else begin a = b; b = c; end
        4'hF: begin
          if (o == 16'd0) begin o = a; a = b; b = o; end
          else if (o == 16'd1) begin a = b + a; b = c; end
          else if (o == 16'd2) begin a = b - a; b = c; end
          else begin eerr = 1; stop = 1; end
        end
        default: begin eerr = 1; stop = 1; end
      endcase
    end
    ea = a; eb = b; ec = c;
  endtask

  task automatic run_prog(input string tag, input bit stall);
    logic [15:0] ea, eb, ec;
    logic eerr;
    bit low_pending, stall_checked;
    logic [11:0] saved;
    int bad;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 16'(i * 7 + 3);
      mmem[i] = 16'(i * 7 + 3);
    end
    model_run(ea, eb, ec, eerr);
    rst_n = 1'b0;
    ibyte_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    low_pending = 0; stall_checked = 0; saved = '0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (halted) break;
      if (low_pending) begin
        chk({tag, " R11 stall holds fetch_addr"}, {4'h0, fetch_addr}, {4'h0, saved});
        chk({tag, " R11 ready held in stall"}, {15'h0, ibyte_ready}, 16'h1);
        low_pending = 0;
        stall_checked = 1;
      end
      ibyte_valid = stall ? ((k % 3) != 2) : 1'b1;
      if (stall && !stall_checked && !ibyte_valid && ibyte_ready) begin
        low_pending = 1;
        saved = fetch_addr;
      end
    end
    chk({tag, " halted"}, {15'h0, halted}, 16'h1);
    chk({tag, " R10 err_flag"}, {15'h0, err_flag}, {15'h0, eerr});
    chk({tag, " A"}, stk_a, ea);
    chk({tag, " B"}, stk_b, eb);
    chk({tag, " C"}, stk_c, ec);
    bad = -1;
    for (int i = 255; i >= 0; i--) if (mem[i] !== mmem[i]) bad = i;
    if (bad >= 0) chk({tag, " R6 memory word"}, mem[bad], mmem[bad]);
    else chk({tag, " R6 memory"}, 16'h0, 16'h0);
    ibyte_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk({tag, " R10 ready low after halt"}, {15'h0, ibyte_ready}, 16'h0);
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0;
    ibyte_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 fetch_addr", {4'h0, fetch_addr}, 16'h0);
    chk("R1 ready", {15'h0, ibyte_ready}, 16'h1);
    chk("R1 A", stk_a, 16'h0);
    chk("R1 B", stk_b, 16'h0);
    chk("R1 C", stk_c, 16'h0);
    chk("R1 halted/err", {14'h0, halted, err_flag}, 16'h0);
  endtask

  task automatic t_ldc_r2();
    load({8'h35, 8'h37, 8'h39, 8'h80}, 4);
    run_prog("R2 R5 load constants", 0);
    chk("R2 A value", stk_a, 16'h0009);
  endtask

  task automatic t_prefix_r3();
    load({8'h21, 8'h22, 8'h33, 8'h34, 8'h80}, 5);
    run_prog("R3 prefix chain", 0);
    chk("R3 wide constant in B", stk_b, 16'h0123);
    chk("R3 operand cleared, A", stk_a, 16'h0004);
  endtask

  task automatic t_nfix_r4();
    load({8'h60, 8'h3F, 8'h61, 8'h30, 8'h60, 8'h21, 8'h30, 8'h80}, 8);
    run_prog("R4 negative prefix", 0);
    chk("R4 minus one in C", stk_c, 16'hFFFF);
    chk("R4 nfix then pfix in A", stk_a, 16'hFF10);
  endtask

  task automatic t_local_r6();
    load({8'h2A, 8'h3B, 8'h53, 8'h25, 8'h35, 8'h21, 8'h52,
          8'h13, 8'h21, 8'h12, 8'h17, 8'h80}, 12);
    run_prog("R6 load/store local", 0);
    chk("R6 stored word 0x43", mem[8'h43], 16'h00AB);
    chk("R6 stored word 0x52", mem[8'h52], 16'h0055);
  endtask

  task automatic t_adc_r7();
    load({8'h37, 8'h41, 8'h2F, 8'h4F, 8'h60, 8'h4E, 8'h80}, 7);
    run_prog("R7 add constant", 0);
    chk("R7 A sum", stk_a, 16'h0105);
  endtask

  task automatic t_opr_r8();
    load({8'h3A, 8'h33, 8'hF2, 8'h35, 8'hF0, 8'hF1, 8'h39, 8'hF2, 8'h80}, 9);
    run_prog("R8 operate", 0);
  endtask

  task automatic t_jump_r9();
    load({8'h02, 8'h3F, 8'h3F, 8'h31, 8'h32, 8'h71, 8'h30, 8'h72,
          8'h3E, 8'h3E, 8'h35, 8'h80}, 12);
    run_prog("R9 jumps", 0);
    chk("R9 A after taken cj", stk_a, 16'h0005);
    chk("R9 C after untaken cj", stk_c, 16'h0001);
  endtask

  task automatic t_err_r10();
    load({8'h37, 8'hF5, 8'h39, 8'h80}, 4);
    run_prog("R10 bad subcode", 0);
    chk("R10 next byte not run", stk_a, 16'h0007);
    load({8'h37, 8'h21, 8'hF0, 8'h39}, 4);
    run_prog("R10 prefixed bad subcode", 0);
    load({8'h37, 8'h90, 8'h39}, 3);
    run_prog("R10 bad direct code", 0);
  endtask

  task automatic t_stall_r11();
    load({8'h3A, 8'h33, 8'hF2, 8'h35, 8'hF0, 8'hF1, 8'h39, 8'hF2, 8'h80}, 9);
    run_prog("R11 stalled operate", 1);
    load({8'h2A, 8'h3B, 8'h53, 8'h25, 8'h35, 8'h21, 8'h52,
          8'h13, 8'h21, 8'h12, 8'h17, 8'h80}, 12);
    run_prog("R11 stalled locals", 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = 8'h80;
    t_reset_r1();
    t_ldc_r2();
    t_prefix_r3();
    t_nfix_r4();
    t_local_r6();
    t_adc_r7();
    t_opr_r8();
    t_jump_r9();
    t_err_r10();
    t_stall_r11();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule